// File: doc/BRIEF.md
# E3 Receive Line Decoder

This block sits directly behind an E3 line interface unit. It takes the receive line clock and two rail inputs, one for positive pulses and one for negative pulses. From them it recovers a single-rail NRZ bit stream and a line code violation flag that marks suspect bits. The line clock is the only clock in the block. Rail capture, decoding and both outputs are all timed from it.

A three-bit control register, written from the line clock domain, selects the decoding at run time. The choices are single-rail pass-through, bipolar AMI, and bipolar HDB3 with removal of the zero-substitution codes. The same register selects which line clock edge captures the rails. Every write clears the block's polarity history and its pipeline, so decoding under the new settings starts from a clean state.

In the bipolar modes, the decoder remembers the polarity of the last single-rail mark and flags any pulse that repeats it. In HDB3 mode, a three-bit window of decoded bits lets the decoder recognise the two substitution shapes and turn them back into four zeros. The same window latency applies in every mode, so the output timing never depends on the selected code.

Top module: `e3_rx_line_decoder`

## Requirements
- R1: After a synchronous reset, rx_data and rx_lcv are 0. The control register is 0, which selects bipolar HDB3 decoding with rail capture on the rising edge.
- R2: Each symbol captured at a rising edge k appears on rx_data/rx_lcv after rising edge k+4, in every mode. An HDB3 stream with no violations other than substitution codes decodes to its original bits with rx_lcv low.
- R3: With cfg_wdata bit 1 set (single rail), rx_data equals the level of rail_p_in at capture, rail_n_in has no effect, and rx_lcv stays 0.
- R4: In bipolar AMI mode (cfg_wdata bit 1 = 0, bit 2 = 1), a pulse on exactly one rail decodes as 1 and no pulse decodes as 0.
- R5: In AMI mode, a pulse with the same polarity as the previous single-rail pulse decodes as 1 with rx_lcv high on that bit. No zero substitution is undone in this mode.
- R6: In HDB3 mode (bits 1 and 2 both 0), the pattern zero, zero, zero, then a pulse that repeats the last polarity, decodes as four 0 bits with rx_lcv low.
- R7: In HDB3 mode, the pattern of an alternating pulse, zero, zero, then a pulse repeating that polarity, decodes as four 0 bits with rx_lcv low.
- R8: In HDB3 mode, a polarity repeat whose two preceding symbols are not both zero decodes as 1 with rx_lcv high on that bit.
- R9: In either bipolar mode, pulses on both rails at once decode as 1 with rx_lcv high. Such a pulse does not change the remembered polarity. rx_lcv is never high on a 0 output bit.
- R10: With cfg_wdata bit 0 set, the rails are captured at the falling edge of line_clk. The result moves into the pipeline at the following rising edge, and the level at the rising edge is ignored.
- R11: A cycle with cfg_we high loads the register and clears the polarity history and all pipeline stages. Outputs are 0 after that edge until new symbols emerge, and the first pulse afterwards is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Receive line clock, the only timing source |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit 0 falling-edge capture, bit 1 single rail, bit 2 AMI instead of HDB3 |
| rail_p_in | input | 1 | Positive rail (single-rail data in unipolar mode) |
| rail_n_in | input | 1 | Negative rail |
| rx_data | output | 1 | Decoded NRZ data |
| rx_lcv | output | 1 | Line code violation flag, aligned with its bit |

## Verification
A stale polarity history shows at the ports as a spurious or missing rx_lcv on the first pulse after a configuration write. That error is visible four cycles after the pulse is captured. A wrong substitution window leaves a stray 1 in place of a zero run, or an unflagged repeat. Either appears within the same four-cycle latency and is caught when that bit is compared. The rails are driven with the opposite value around the edge that should be ignored, so a capture on the wrong edge corrupts every compared bit.

// File: rtl/e3rx_pkg.sv
package e3rx_pkg;

    // Substitution code length of HDB3; the window holds one less
    localparam int ZS_LEN = 4;
    localparam int WIN_DEPTH = ZS_LEN - 1;

    // Control register layout
    localparam int CFG_W       = 3;
    localparam int CFG_INV_BIT = 0;
    localparam int CFG_UNI_BIT = 1;
    localparam int CFG_AMI_BIT = 2;

    typedef enum logic [1:0] {
        LM_HDB3 = 2'd0,
        LM_AMI  = 2'd1,
        LM_UNI  = 2'd2
    } line_mode_e;

    typedef struct packed {
        logic edge_inv;
        logic single_rail;
        logic ami_sel;
    } rx_cfg_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    typedef struct packed {
        logic mark;   // a pulse was seen
        logic pol;    // 1 = positive rail
        logic bpv;    // repeat of the last polarity
        logic dual;   // both rails at once
    } line_sym_t;

    typedef struct packed {
        logic data;
        logic lcv;
    } rx_bit_t;

    function automatic rx_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        rx_cfg_t c;
        c.edge_inv    = w[CFG_INV_BIT];
        c.single_rail = w[CFG_UNI_BIT];
        c.ami_sel     = w[CFG_AMI_BIT];
        return c;
    endfunction

    function automatic line_mode_e mode_of(input rx_cfg_t c);
        line_mode_e m;
        if (c.single_rail)  m = LM_UNI;
        else if (c.ami_sel) m = LM_AMI;
        else                m = LM_HDB3;
        return m;
    endfunction

endpackage

// File: rtl/e3rx_rail_sampler.sv
module e3rx_rail_sampler
    import e3rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       edge_inv,
    input  logic       rail_p,
    input  logic       rail_n,
    output rail_pair_t smp_o
);

    rail_pair_t fall_q;
    rail_pair_t smp_q;

    // Falling-edge capture, used when the inverted edge is selected
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q.pos <= rail_p;
            fall_q.neg <= rail_n;
        end
    end

    // Every capture lands in the rising-edge domain here
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            smp_q <= '0;
        end else if (edge_inv) begin
            smp_q <= fall_q;
        end else begin
            smp_q.pos <= rail_p;
            smp_q.neg <= rail_n;
        end
    end

    assign smp_o = smp_q;

    // R11: a write leaves an empty capture stage behind
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (smp_q == '0));

endmodule

// File: rtl/e3rx_polarity_tracker.sv
module e3rx_polarity_tracker
    import e3rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  line_mode_e mode,
    input  rail_pair_t smp_i,
    output line_sym_t  sym_o
);

    logic hist_vld_q;
    logic last_pol_q;

    always_comb begin
        sym_o = '0;
        if (mode == LM_UNI) begin
            sym_o.mark = smp_i.pos;
        end else if (smp_i.pos && smp_i.neg) begin
            sym_o.mark = 1'b1;
            sym_o.dual = 1'b1;
        end else if (smp_i.pos || smp_i.neg) begin
            sym_o.mark = 1'b1;
            sym_o.pol  = smp_i.pos;
            sym_o.bpv  = hist_vld_q && (last_pol_q == smp_i.pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist_vld_q <= 1'b0;
            last_pol_q <= 1'b0;
        end else if (mode != LM_UNI && sym_o.mark && !sym_o.dual) begin
            hist_vld_q <= 1'b1;
            last_pol_q <= sym_o.pol;
        end
    end

    // R11: the first symbol after a clear is never a polarity repeat
    p_clean_after_flush_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !sym_o.bpv);

    // R3: single-rail decoding never reports a polarity repeat
    p_uni_no_bpv_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == LM_UNI) |-> !sym_o.bpv);

endmodule

// File: rtl/e3rx_zs_window.sv
module e3rx_zs_window
    import e3rx_pkg::*;
#(
    parameter int DEPTH = WIN_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  line_mode_e mode,
    input  line_sym_t  sym_i,
    output rx_bit_t    bit_o
);

    rx_bit_t win_q [DEPTH];
    rx_bit_t out_q;
    rx_bit_t head;
    logic    lead_zero;
    logic    tail_mark;
    logic    subst;
    logic    take_b;

    // Pattern match on the window ahead of an incoming repeat
    always_comb begin
        lead_zero = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (win_q[i].data) lead_zero = 1'b0;
        end
        tail_mark = win_q[DEPTH-1].data;
        subst     = (mode == LM_HDB3) && sym_i.bpv && !sym_i.dual
                    && lead_zero && !win_q[DEPTH-1].lcv;
        take_b    = subst && tail_mark;
    end

    always_comb begin
        head.data = sym_i.mark && !subst;
        head.lcv  = sym_i.dual || (sym_i.bpv && !subst);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
            out_q <= '0;
        end else begin
            out_q.data <= win_q[DEPTH-1].data && !take_b;
            out_q.lcv  <= win_q[DEPTH-1].lcv  && !take_b;
            win_q[0]   <= head;
            for (int i = 1; i < DEPTH; i++) win_q[i] <= win_q[i-1];
        end
    end

    assign bit_o = out_q;

    // R7: a recognised leading pulse leaves as a clean zero
    p_b_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        (!flush && take_b) |=> (!bit_o.data && !bit_o.lcv));

    // R6: a substituted repeat enters the window as a clean zero
    p_v_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        (!flush && subst) |=> (!win_q[0].data && !win_q[0].lcv));

    // R3: no flag enters the window in single-rail mode
    p_uni_no_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (!flush && mode == LM_UNI) |=> !win_q[0].lcv);

endmodule

// File: rtl/e3_rx_line_decoder.sv
module e3_rx_line_decoder
    import e3rx_pkg::*;
(
    input  logic             line_clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rail_p_in,
    input  logic             rail_n_in,
    output logic             rx_data,
    output logic             rx_lcv
);

    logic [CFG_W-1:0] cfg_q;
    rx_cfg_t          cfg;
    line_mode_e       mode;
    rail_pair_t       smp;
    line_sym_t        sym;
    rx_bit_t          dec;

    always_ff @(posedge line_clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    always_comb begin
        cfg  = cfg_unpack(cfg_q);
        mode = mode_of(cfg);
    end

    e3rx_rail_sampler u_sampler (
        .clk      (line_clk),
        .rst      (rst),
        .flush    (cfg_we),
        .edge_inv (cfg.edge_inv),
        .rail_p   (rail_p_in),
        .rail_n   (rail_n_in),
        .smp_o    (smp)
    );

    e3rx_polarity_tracker u_tracker (
        .clk   (line_clk),
        .rst   (rst),
        .flush (cfg_we),
        .mode  (mode),
        .smp_i (smp),
        .sym_o (sym)
    );

    e3rx_zs_window #(.DEPTH(WIN_DEPTH)) u_window (
        .clk   (line_clk),
        .rst   (rst),
        .flush (cfg_we),
        .mode  (mode),
        .sym_i (sym),
        .bit_o (dec)
    );

    assign rx_data = dec.data;
    assign rx_lcv  = dec.lcv;

    // R11: outputs are quiet right after a register write
    p_write_quiet_r11: assert property (@(posedge line_clk) disable iff (rst)
        cfg_we |=> (!rx_data && !rx_lcv));

    // R9: a flag only ever accompanies a 1
    p_flag_on_one_r9: assert property (@(posedge line_clk) disable iff (rst)
        rx_lcv |-> rx_data);

endmodule

// File: tb/e3_rx_line_decoder_tb_top.sv
module e3_rx_line_decoder_tb_top;
    import e3rx_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             rp = 1'b0;
    logic             rn = 1'b0;
    logic             rx_data;
    logic             rx_lcv;

    e3_rx_line_decoder dut_i (
        .line_clk  (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rail_p_in (rp),
        .rail_n_in (rn),
        .rx_data   (rx_data),
        .rx_lcv    (rx_lcv)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit inv_mode = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  d;
        logic  l;
        string tag;
    } exp_t;

    exp_t sbq[$];

    task automatic check(input string tag, input logic ad, input logic al,
                         input logic ed, input logic el);
        n_chk++;
        if (ad !== ed || al !== el) begin
            n_fail++;
            $display("FAIL %s: data=%b lcv=%b, expected data=%b lcv=%b (cycle %0d)",
                     tag, ad, al, ed, el, cyc);
        end
    endtask

    // Driver: one symbol per cycle, opposite level around the unused edge
    task automatic drive(input logic p, input logic n, input logic ed,
                         input logic el, input string tag);
        exp_t e;
        if (!inv_mode) begin
            @(negedge clk);
            rp = p; rn = n;
            e.due = cyc + 5; e.d = ed; e.l = el; e.tag = tag;
            sbq.push_back(e);
            @(posedge clk); #1;
            rp = !p; rn = !n;
        end else begin
            @(posedge clk); #1;
            rp = p; rn = n;
            e.due = cyc + 5; e.d = ed; e.l = el; e.tag = tag;
            sbq.push_back(e);
            @(negedge clk); #1;
            rp = !p; rn = !n;
        end
    endtask

    // Monitor: pop and compare items as they fall due
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                e = sbq.pop_front();
                if (e.due < cyc) check({e.tag, " missed"}, 1'bx, 1'bx, e.d, e.l);
                else             check(e.tag, rx_data, rx_lcv, e.d, e.l);
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, "R2");
        rp = 1'b0; rn = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        inv_mode = v[CFG_INV_BIT];
        check("R11", rx_data, rx_lcv, 1'b0, 1'b0);
    endtask

    // Bench-side line coder: AMI, or HDB3 when use_zs is set
    task automatic send_coded(input logic [63:0] bits, input int nb, input bit use_zs);
        bit last  = 1'b0;
        int marks = 0;
        int i     = 0;
        while (i < nb) begin
            if (bits[i]) begin
                last = !last;
                drive(last, !last, 1'b1, 1'b0, use_zs ? "R2" : "R4");
                marks++;
                i++;
            end else if (use_zs && i + 3 < nb && bits[i +: 4] == 4'b0000) begin
                if (marks % 2 == 1) begin
                    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, "R6");
                    drive(last, !last, 1'b0, 1'b0, "R6");
                end else begin
                    last = !last;
                    drive(last, !last, 1'b0, 1'b0, "R7");
                    for (int k = 0; k < 2; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, "R7");
                    drive(last, !last, 1'b0, 1'b0, "R7");
                end
                marks = 0;
                i += 4;
            end else begin
                drive(1'b0, 1'b0, 1'b0, 1'b0, use_zs ? "R2" : "R4");
                i++;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(1_500_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1", rx_data, rx_lcv, 1'b0, 1'b0);

        // R1/R2/R6/R7: default register selects HDB3, rising-edge capture
        send_coded(64'h8000_0C00_0010_0E01, 64, 1'b1);
        drain();

        // R8/R9: unmatched repeat, dual pulse, history kept across dual
        write_cfg(3'b000);
        drive(1'b1, 1'b0, 1'b1, 1'b0, "R8");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        drive(1'b1, 1'b0, 1'b1, 1'b1, "R8");
        drive(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        drive(1'b0, 1'b1, 1'b1, 1'b0, "R9");
        drive(1'b0, 1'b1, 1'b1, 1'b1, "R8");
        drain();

        // R4/R5: AMI decoding, repeats flagged, no substitution removal
        write_cfg(3'b100);
        send_coded(64'h0000_00AD_0F0F_8001, 40, 1'b0);
        drain();
        write_cfg(3'b100);
        drive(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b0, 1'b1, 1'b1, "R5");
        drive(1'b1, 1'b1, 1'b1, 1'b1, "R9");
        drive(1'b0, 1'b1, 1'b1, 1'b0, "R4");
        drain();

        // R11: a write drops symbols in flight and clears the history
        @(negedge clk); rp = 1'b1; rn = 1'b0;
        @(negedge clk); rp = 1'b0; rn = 1'b1;
        @(negedge clk); rp = 1'b0; rn = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 3'b100;
        @(negedge clk); cfg_we = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check("R11", rx_data, rx_lcv, 1'b0, 1'b0);
            @(negedge clk);
        end
        drive(1'b0, 1'b1, 1'b1, 1'b0, "R11");
        drain();

        // R3: single rail, negative rail carries noise
        write_cfg(3'b010);
        begin
            logic [31:0] pd = 32'hC3A5_19E6;
            logic [31:0] nd = 32'h5F0C_A371;
            for (int k = 0; k < 32; k++) drive(pd[k], nd[k], pd[k], 1'b0, "R3");
        end
        drain();

        // R10: falling-edge capture, single rail then HDB3
        write_cfg(3'b011);
        begin
            logic [23:0] pd = 24'h9C_35E1;
            for (int k = 0; k < 24; k++) drive(pd[k], 1'b1, pd[k], 1'b0, "R10");
        end
        drain();
        write_cfg(3'b001);
        send_coded(64'h0000_0000_0081_0E01, 24, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 1'b1, "R10");
        drain();

        finish_run();
    end

endmodule